// File: doc/BRIEF.md
# Return Address Stack

This block keeps return addresses for a microsequencer: the addresses to come back to after a subroutine, and the heads of loops. It is a last-in, first-out store of nine 12-bit words. The top word is always visible on the output, so a loop can branch back to it any number of times without removing it. Each clock edge applies at most one operation: clear, push, pop, or hold when nothing is requested.

The decoder that issues the requests lies outside the block. Requests and the push value are sampled on the same rising edge. The new top word and the new full flag appear right after that edge. Overflow and underflow are tolerated and do no harm. A push onto a full stack replaces the top word, and a pop from an empty stack leaves the stack empty.

Top module: `rtn_stack`

## Requirements
- R1: After an asynchronous reset (rst_ni low) the stack is empty, top_o is 0 and full_no is 1.
- R2: A push on a stack holding fewer than nine words adds push_data_i as the new top. It is visible on top_o right after that clock edge, and the depth grows by one.
- R3: A pop on a non-empty stack removes the top word. The word below it, or 0 if none remains, appears on top_o after the edge.
- R4: A clear empties the stack in one edge, whatever the prior depth.
- R5: full_no is 0 exactly when nine words are held. It falls right after the edge of the ninth net push and rises after the next pop or clear.
- R6: A push on a full stack replaces the top word with push_data_i, and the depth stays nine. The eight words below are unchanged, which shows when they are popped.
- R7: A pop on an empty stack leaves it empty with top_o at 0. The next push then produces a depth of one.
- R8: With no request, depth and contents are unchanged, so top_o reads the same word on every following cycle.
- R9: Simultaneous requests resolve as clear over push over pop. Clear with push leaves the stack empty. Push with pop acts as a push alone.
- R10: top_o is 0 whenever the stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Empty the stack |
| push_i | input | 1 | Push push_data_i |
| pop_i | input | 1 | Remove the top word |
| push_data_i | input | 12 | Value to push |
| top_o | output | 12 | Current top word, 0 when empty |
| full_no | output | 1 | Low when nine words are held |

## Verification
Several operations can meet on one edge: push with pop, clear with push, and a push that arrives exactly at the full boundary where writing turns into overwriting. The bench drives these pairs on purpose at depths 0, 1, 8 and 9. It also drives them in a long random mix in which every request bit toggles independently. Every cycle is compared against a queue model that applies the priority order, so a wrong winner shows up as a depth or top-word mismatch on that cycle or at a later pop.

// File: rtl/rtn_stack_pkg.sv
package rtn_stack_pkg;
  localparam int unsigned DEF_DEPTH = 9;
  localparam int unsigned DEF_WIDTH = 12;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_CLEAR = 2'd1,
    OP_PUSH  = 2'd2,
    OP_POP   = 2'd3
  } op_e;
endpackage

// File: rtl/rtn_stack_ctrl.sv
module rtn_stack_ctrl
  import rtn_stack_pkg::*;
#(
  parameter int unsigned DEPTH = DEF_DEPTH,
  localparam int unsigned DW = $clog2(DEPTH + 1),
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          push_i,
  input  logic          pop_i,
  output logic          we_o,
  output logic [PW-1:0] wr_idx_o,
  output logic [PW-1:0] rd_idx_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [DW-1:0] depth_q, depth_d;
  op_e op;

  // fixed priority: clear > push > pop
  always_comb begin
    if (clear_i)     op = OP_CLEAR;
    else if (push_i) op = OP_PUSH;
    else if (pop_i)  op = OP_POP;
    else             op = OP_HOLD;
  end

  assign empty_o = (depth_q == '0);
  assign full_o  = (depth_q == DW'(DEPTH));

  always_comb begin
    depth_d = depth_q;
    unique case (op)
      OP_CLEAR: depth_d = '0;
      OP_PUSH:  if (!full_o) depth_d = depth_q + DW'(1);
      OP_POP:   if (!empty_o) depth_d = depth_q - DW'(1);
      default:  depth_d = depth_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) depth_q <= '0;
    else         depth_q <= depth_d;
  end

  // overwrite in place when full
  assign we_o     = (op == OP_PUSH);
  assign wr_idx_o = full_o ? PW'(DEPTH - 1) : PW'(depth_q);
  assign rd_idx_o = empty_o ? '0 : PW'(depth_q - DW'(1));

  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_q <= DW'(DEPTH));
  a_r4_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> empty_o);
  a_r2_push_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !clear_i && !full_o) |=> (depth_q == $past(depth_q) + DW'(1)));
  a_r6_full_push_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !clear_i && full_o) |=> full_o);
  a_r7_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !clear_i && empty_o) |=> empty_o);
  a_r8_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pop_i && !push_i && !clear_i) |=> $stable(depth_q));
  a_r9_push_beats_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !clear_i && !full_o) |=> !empty_o);
endmodule

// File: rtl/rtn_stack_file.sv
module rtn_stack_file #(
  parameter int unsigned DEPTH = 9,
  parameter int unsigned WIDTH = 12,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [PW-1:0]    wr_idx_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic [PW-1:0]    rd_idx_i,
  input  logic             empty_i,
  output logic [WIDTH-1:0] rd_data_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            mem_q[i] <= '0;
      else if (we_i && wr_idx_i == PW'(i))    mem_q[i] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (!empty_i && (32'(rd_idx_i) < DEPTH)) rd_data_o = mem_q[rd_idx_i];
  end

  a_r10_empty_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_i |-> (rd_data_o == '0));
  a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !empty_i && wr_idx_i == rd_idx_i) |=> $past(wr_data_i) == mem_q[$past(wr_idx_i)]);
endmodule

// File: rtl/rtn_stack.sv
module rtn_stack
  import rtn_stack_pkg::*;
#(
  parameter int unsigned DEPTH = DEF_DEPTH,
  parameter int unsigned WIDTH = DEF_WIDTH,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] push_data_i,
  output logic [WIDTH-1:0] top_o,
  output logic             full_no
);
  logic          we, empty, full;
  logic [PW-1:0] wr_idx, rd_idx;

  rtn_stack_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear_i),
    .push_i   (push_i),
    .pop_i    (pop_i),
    .we_o     (we),
    .wr_idx_o (wr_idx),
    .rd_idx_o (rd_idx),
    .empty_o  (empty),
    .full_o   (full)
  );

  rtn_stack_file #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_file (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we),
    .wr_idx_i  (wr_idx),
    .wr_data_i (push_data_i),
    .rd_idx_i  (rd_idx),
    .empty_i   (empty),
    .rd_data_o (top_o)
  );

  assign full_no = ~full;

  a_r5_full_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !clear_i && !full_no) |=> !full_no);
endmodule

// File: tb/rtn_stack_test.sv
module rtn_stack_test;
  localparam int DEPTH = 9;
  localparam int WIDTH = 12;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             clear_i = 1'b0, push_i = 1'b0, pop_i = 1'b0;
  logic [WIDTH-1:0] push_data_i = '0;
  logic [WIDTH-1:0] top_o;
  logic             full_no;

  int vectors = 0;
  int errors  = 0;
  int model[$];
  bit done = 1'b0;

  always #4 clk = ~clk;

  rtn_stack #(.DEPTH(DEPTH), .WIDTH(WIDTH)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .clear_i(clear_i), .push_i(push_i),
    .pop_i(pop_i), .push_data_i(push_data_i), .top_o(top_o), .full_no(full_no)
  );

  task automatic compare(input string tag);
    logic [WIDTH-1:0] exp_top;
    logic             exp_full_n;
    exp_top    = (model.size() == 0) ? '0 : WIDTH'(model[$]);
    exp_full_n = (model.size() != DEPTH);
    vectors++;
    if (top_o !== exp_top || full_no !== exp_full_n) begin
      errors++;
      $display("FAIL %s: top=%h full_n=%b expected top=%h full_n=%b",
               tag, top_o, full_no, exp_top, exp_full_n);
    end
  endtask

  task automatic step(input bit c, input bit p, input bit o,
                      input logic [WIDTH-1:0] d, input string tag);
    @(negedge clk);
    clear_i = c; push_i = p; pop_i = o; push_data_i = d;
    @(posedge clk);
    if (c) model.delete();
    else if (p) begin
      if (model.size() < DEPTH) model.push_back(int'(d));
      else model[DEPTH-1] = int'(d);
    end else if (o) begin
      if (model.size() > 0) void'(model.pop_back());
    end
    #2;
    compare(tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    #10;
    compare("R1");            // reset state, R10 top zero
    @(negedge clk);
    rst_ni = 1'b1;
    compare("R1");

    step(0, 1, 0, 12'h0a1, "R2");
    step(0, 1, 0, 12'h0b2, "R2");
    step(0, 1, 0, 12'h0c3, "R2");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 12'hfff, "R8");
    step(0, 0, 1, 12'h000, "R3");
    step(0, 0, 1, 12'h000, "R3");
    step(0, 0, 1, 12'h000, "R10");
    step(0, 0, 1, 12'h000, "R7");
    step(0, 0, 1, 12'h000, "R7");
    step(0, 1, 0, 12'h123, "R7");
    step(0, 0, 1, 12'h000, "R3");

    for (int i = 0; i < DEPTH; i++) step(0, 1, 0, WIDTH'(12'h100 + i), "R5");
    step(0, 1, 0, 12'habc, "R6");
    step(0, 1, 0, 12'hdef, "R6");
    step(0, 1, 1, 12'h777, "R6");
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 12'h000, "R6");

    step(0, 1, 0, 12'h055, "R2");
    step(1, 1, 0, 12'h066, "R9");
    step(0, 1, 1, 12'h077, "R9");
    step(0, 1, 1, 12'h088, "R9");
    step(1, 0, 1, 12'h000, "R9");
    for (int i = 0; i < 5; i++) step(0, 1, 0, WIDTH'(12'h200 + i), "R2");
    step(1, 0, 0, 12'h000, "R4");
    step(0, 0, 0, 12'h000, "R4");

    for (int i = 0; i < 3000; i++) begin
      logic [7:0] r;
      r = 8'($urandom);
      step(r[7:4] == 4'h0, r[1] | r[3], r[0] | r[2], WIDTH'($urandom), "R9");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule